// File: doc/BRIEF.md
# Scatter-Gather DMA Channel with Chained Descriptors

This block is one DMA channel that copies data between memory regions that need not be contiguous. Software places the first segment's settings straight into the channel registers, then sets the enable bit. From there on, the channel works on its own. At the end of each segment it reads the next linked item from memory, reloads its settings and carries on, until it reaches a null link. A rectangular window cut out of a larger image is one example: each row becomes one segment, and the links chain the rows together.

Each linked item is four 32-bit words in memory. Data and descriptor traffic share one request/acknowledge master port. A data element travels right-aligned on the data buses. At the end of a segment the channel can raise a terminal-count interrupt. The interrupt is gated twice: once by a bit in the item's control word and once by a mask bit in the channel configuration. This lets software choose an interrupt after every segment or only after the last one. A pending interrupt stays set until software writes a one to clear it.

Top module: `sg_dma_channel`

## Requirements
- R1: After reset, `tc_irq` is 0, `mem_req` is 0 and the configuration register (address 4) reads as 0.
- R2: Register addresses: 0 source, 1 destination, 2 link, 3 control (writable only while idle), 4 configuration (bit 0 enable/start, bit 1 interrupt mask), 5 interrupt clear. Writing 1 to configuration bit 0 while idle starts a segment of `ctrl[11:0]` elements, with element width set by `ctrl[13:12]` (0 byte, 1 halfword, 2 word).
- R3: Within a segment, `ctrl[14]=1` steps the source address by the element size after each element, and `ctrl[15]=1` does the same for the destination address. When either bit is 0, that address stays fixed.
- R4: When a segment ends with a link whose bits [31:2] are non-zero, the channel issues four word reads at the link with its low two bits cleared, plus offsets 0, 4, 8 and 12. These words load source, destination, link and control, in that order. The next segment then runs with no register access.
- R5: When a segment ends and link bits [31:2] are zero, the channel returns to idle and configuration bit 0 reads 0.
- R6: A segment with a count of 0 moves no data, counts as a completed segment and follows its link.
- R7: A completed segment sets the pending interrupt only when `ctrl[31]` of that segment and configuration bit 1 are both 1.
- R8: The pending interrupt drives `tc_irq` (and register 5 bit 0). It stays set until software writes register 5 with bit 0 = 1. A write with bit 0 = 0 does not change it.
- R9: Once `mem_req` is high without `mem_ack`, it stays high with the same address and direction in the next cycle.
- R10: While the channel is idle, `mem_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access width: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Right-aligned read data, valid with `mem_ack` |
| tc_irq | output | 1 | Pending terminal-count interrupt |

## Verification
The checker looks at the memory handshake on every cycle. It confirms that requests are held until acknowledged (R9), that no request appears while idle (R10), and that every descriptor fetch is an aligned word read (R4). It also checks that the enable bit has dropped by the time the channel leaves its busy states (R5), that the interrupt only rises under the mask (R7), and that a clear write takes effect (R8). Only the bench scenarios can show whether the right bytes reach the right places. They cover the widths and increment modes, the data moved across a three-item chain containing a zero-count item, and how many interrupts each gating combination produces.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_FETCH,
      ST_READ,
      ST_WRITE,
      ST_DONE
   } sg_state_e;

   localparam logic [2:0] RA_SRC    = 3'd0;
   localparam logic [2:0] RA_DST    = 3'd1;
   localparam logic [2:0] RA_LINK   = 3'd2;
   localparam logic [2:0] RA_CTRL   = 3'd3;
   localparam logic [2:0] RA_CFG    = 3'd4;
   localparam logic [2:0] RA_IRQCLR = 3'd5;

   localparam int CTL_WID_LO = 12;
   localparam int CTL_SINC   = 14;
   localparam int CTL_DINC   = 15;
   localparam int CTL_IE     = 31;

   function automatic logic [2:0] elem_bytes(input logic [1:0] wid);
      case (wid)
         2'd0:    elem_bytes = 3'd1;
         2'd1:    elem_bytes = 3'd2;
         default: elem_bytes = 3'd4;
      endcase
   endfunction

   function automatic logic [1:0] bus_size(input logic [1:0] wid);
      bus_size = (wid == 2'd3) ? 2'd2 : wid;
   endfunction

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
   import sgdma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [2:0] reg_addr,
   input  logic       wbit0,
   input  logic       wbit1,
   input  logic       busy,
   input  logic       chain_done,
   output logic       cfg_en,
   output logic       cfg_mask,
   output logic       start,
   output logic       irq_clr
);

   logic cfg_wr;

   assign cfg_wr  = reg_we && (reg_addr == RA_CFG);
   assign start   = cfg_wr && wbit0 && !cfg_en && !busy;
   assign irq_clr = reg_we && (reg_addr == RA_IRQCLR) && wbit0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_en   <= 1'b0;
         cfg_mask <= 1'b0;
      end else begin
         if (cfg_wr) cfg_mask <= wbit1;
         if (chain_done) cfg_en <= 1'b0;
         else if (start) cfg_en <= 1'b1;
      end
   end

endmodule

// File: rtl/sgdma_irq.sv
module sgdma_irq #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seg_done,
   input  logic seg_ie,
   input  logic cfg_mask,
   input  logic irq_clr,
   output logic irq_set,
   output logic irq
);

   assign irq_set = seg_done && seg_ie && cfg_mask;

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk) begin
            if (!rst_n)       irq <= 1'b0;
            else if (irq_set) irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk) begin
            if (!rst_n)       irq <= 1'b0;
            else if (irq_clr) irq <= 1'b0;
            else if (irq_set) irq <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
   import sgdma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int CNT_W = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          desc_we,
   input  logic [1:0]    desc_sel,
   input  logic [DW-1:0] desc_wdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          seg_done,
   output logic          seg_ie,
   output logic          chain_done,
   output logic          busy,
   output logic          fetching,
   output logic [AW-1:0] cur_src,
   output logic [AW-1:0] cur_dst,
   output logic [AW-1:0] cur_link,
   output logic [DW-1:0] cur_ctrl
);

   localparam int WORD_BYTES = DW / 8;

   sg_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [AW-1:0]     fbase;
   logic [1:0]        fidx;
   logic [DW-1:0]     dlatch;
   logic [1:0]        wid;
   logic [2:0]        step;
   logic [AW-1:0]     src_step;
   logic [AW-1:0]     dst_step;
   logic              link_live;
   logic [DW-1:0]     rd_masked;
   logic              xfer;

   assign wid       = cur_ctrl[CTL_WID_LO+1:CTL_WID_LO];
   assign step      = elem_bytes(wid);
   assign src_step  = cur_ctrl[CTL_SINC] ? AW'(step) : '0;
   assign dst_step  = cur_ctrl[CTL_DINC] ? AW'(step) : '0;
   assign link_live = |cur_link[AW-1:2];
   assign xfer      = mem_req && mem_ack;

   assign busy       = (st != ST_IDLE);
   assign fetching   = (st == ST_FETCH);
   assign seg_done   = (st == ST_CHECK) && (cnt == '0);
   assign seg_ie     = cur_ctrl[CTL_IE];
   assign chain_done = (st == ST_DONE);

   always_comb begin
      case (bus_size(wid))
         2'd0:    rd_masked = {{(DW-8){1'b0}},  mem_rdata[7:0]};
         2'd1:    rd_masked = {{(DW-16){1'b0}}, mem_rdata[15:0]};
         default: rd_masked = mem_rdata;
      endcase
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_size  = 2'd2;
      mem_wdata = '0;
      case (st)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = fbase + AW'({fidx, 2'b00});
         end
         ST_READ: begin
            mem_req  = 1'b1;
            mem_addr = cur_src;
            mem_size = bus_size(wid);
         end
         ST_WRITE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_dst;
            mem_size  = bus_size(wid);
            mem_wdata = dlatch;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         fbase    <= '0;
         fidx     <= '0;
         dlatch   <= '0;
         cur_src  <= '0;
         cur_dst  <= '0;
         cur_link <= '0;
         cur_ctrl <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (desc_we) begin
                  case (desc_sel)
                     2'd0: cur_src  <= desc_wdata;
                     2'd1: cur_dst  <= desc_wdata;
                     2'd2: cur_link <= desc_wdata;
                     default: begin
                        cur_ctrl <= desc_wdata;
                        cnt      <= desc_wdata[CNT_W-1:0];
                     end
                  endcase
               end
               if (start) st <= ST_CHECK;
            end
            ST_CHECK: begin
               if (cnt != '0) begin
                  st <= ST_READ;
               end else if (link_live) begin
                  fbase <= {cur_link[AW-1:2], 2'b00};
                  fidx  <= 2'd0;
                  st    <= ST_FETCH;
               end else begin
                  st <= ST_DONE;
               end
            end
            ST_FETCH: begin
               if (xfer) begin
                  case (fidx)
                     2'd0: cur_src  <= mem_rdata;
                     2'd1: cur_dst  <= mem_rdata;
                     2'd2: cur_link <= mem_rdata;
                     default: begin
                        cur_ctrl <= mem_rdata;
                        cnt      <= mem_rdata[CNT_W-1:0];
                     end
                  endcase
                  fidx <= fidx + 2'd1;
                  if (fidx == 2'd3) st <= ST_CHECK;
               end
            end
            ST_READ: begin
               if (xfer) begin
                  dlatch <= rd_masked;
                  st     <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (xfer) begin
                  cnt     <= cnt - 1'b1;
                  cur_src <= cur_src + src_step;
                  cur_dst <= cur_dst + dst_step;
                  st      <= ST_CHECK;
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   generate
      if (WORD_BYTES != 4) begin : g_bad_word
         $error("sgdma_engine: descriptor words must be 32 bits");
      end
   endgenerate

endmodule

// File: rtl/sg_dma_channel.sv
module sg_dma_channel
   import sgdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              tc_irq
);

   generate
      if (ADDR_W != 32 || DATA_W != 32) begin : g_bad_bus
         $error("sg_dma_channel: address and data buses must be 32 bits");
      end
      if (CNT_W < 1 || CNT_W > 12) begin : g_bad_cnt
         $error("sg_dma_channel: CNT_W must lie in 1..12");
      end
   endgenerate

   logic              cfg_en, cfg_mask, start, irq_clr, irq_set;
   logic              seg_done, seg_ie, chain_done, busy, fetching;
   logic              desc_we;
   logic [ADDR_W-1:0] cur_src, cur_dst, cur_link;
   logic [DATA_W-1:0] cur_ctrl;

   assign desc_we = reg_we && (reg_addr <= RA_CTRL) && !busy;

   sgdma_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .wbit0      (reg_wdata[0]),
      .wbit1      (reg_wdata[1]),
      .busy       (busy),
      .chain_done (chain_done),
      .cfg_en     (cfg_en),
      .cfg_mask   (cfg_mask),
      .start      (start),
      .irq_clr    (irq_clr)
   );

   sgdma_engine #(
      .AW    (ADDR_W),
      .DW    (DATA_W),
      .CNT_W (CNT_W)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .desc_we    (desc_we),
      .desc_sel   (reg_addr[1:0]),
      .desc_wdata (reg_wdata),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_size   (mem_size),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .seg_done   (seg_done),
      .seg_ie     (seg_ie),
      .chain_done (chain_done),
      .busy       (busy),
      .fetching   (fetching),
      .cur_src    (cur_src),
      .cur_dst    (cur_dst),
      .cur_link   (cur_link),
      .cur_ctrl   (cur_ctrl)
   );

   sgdma_irq #(.SET_WINS(1'b1)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .seg_done (seg_done),
      .seg_ie   (seg_ie),
      .cfg_mask (cfg_mask),
      .irq_clr  (irq_clr),
      .irq_set  (irq_set),
      .irq      (tc_irq)
   );

   always_comb begin
      case (reg_addr)
         RA_SRC:    reg_rdata = cur_src;
         RA_DST:    reg_rdata = cur_dst;
         RA_LINK:   reg_rdata = cur_link;
         RA_CTRL:   reg_rdata = cur_ctrl;
         RA_CFG:    reg_rdata = {{(DATA_W-2){1'b0}}, cfg_mask, cfg_en};
         RA_IRQCLR: reg_rdata = {{(DATA_W-1){1'b0}}, tc_irq};
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sgdma_chk.sv
module sgdma_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [2:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [1:0]  mem_size,
   input logic        mem_ack,
   input logic        tc_irq,
   input logic        busy,
   input logic        fetching,
   input logic        cfg_en,
   input logic        cfg_mask,
   input logic        irq_set
);

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fetching |-> (mem_addr[1:0] == 2'b00 && mem_size == 2'd2 && !mem_we));

   assert_enable_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !cfg_en);

   assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_irq) |-> $past(cfg_mask));

   assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd5 && reg_wdata[0] && !irq_set) |=> !tc_irq);

endmodule

bind sg_dma_channel sgdma_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_size  (mem_size),
   .mem_ack   (mem_ack),
   .tc_irq    (tc_irq),
   .busy      (busy),
   .fetching  (fetching),
   .cfg_en    (cfg_en),
   .cfg_mask  (cfg_mask),
   .irq_set   (irq_set)
);

// File: tb/sg_dma_channel_tb.sv
module sg_dma_channel_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd4;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [1:0]  mem_size;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        tc_irq;

   always #4 clk = ~clk;

   sg_dma_channel u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_size  (mem_size),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .tc_irq    (tc_irq)
   );

   logic [7:0] mem_b [1024];
   logic [7:0] ref_b [1024];
   int n_checks = 0;
   int n_fail = 0;

   function automatic int nbytes(input logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else if (mem_req && !mem_ack) begin
         logic [31:0] rd;
         rd = '0;
         for (int b = 0; b < nbytes(mem_size); b++) begin
            if (mem_we) mem_b[(mem_addr + b) & 32'h3FF] = mem_wdata[8*b +: 8];
            else rd[8*b +: 8] = mem_b[(mem_addr + b) & 32'h3FF];
         end
         mem_rdata <= rd;
         mem_ack   <= 1'b1;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   typedef struct packed {
      logic [9:0]  src;
      logic [9:0]  dst;
      logic [11:0] cnt;
      logic [1:0]  wid;
      logic        sinc;
      logic        dinc;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{src:10'h100, dst:10'h200, cnt:12'd7, wid:2'd0, sinc:1'b1, dinc:1'b1},
      '{src:10'h110, dst:10'h240, cnt:12'd5, wid:2'd1, sinc:1'b1, dinc:1'b1},
      '{src:10'h120, dst:10'h280, cnt:12'd4, wid:2'd2, sinc:1'b1, dinc:1'b1},
      '{src:10'h130, dst:10'h2C0, cnt:12'd3, wid:2'd2, sinc:1'b0, dinc:1'b1},
      '{src:10'h140, dst:10'h2F0, cnt:12'd4, wid:2'd0, sinc:1'b1, dinc:1'b0}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(input bit ie, input bit dinc, input bit sinc,
                                           input logic [1:0] wid, input logic [11:0] cnt);
      return {ie, 15'b0, dinc, sinc, wid, cnt};
   endfunction

   task automatic fill(input int seed);
      for (int i = 0; i < 1024; i++) begin
         mem_b[i] = 8'(i * 13 + seed);
         ref_b[i] = mem_b[i];
      end
   endtask

   task automatic put_word(input int a, input logic [31:0] w);
      for (int b = 0; b < 4; b++) begin
         mem_b[(a + b) & 1023] = w[8*b +: 8];
         ref_b[(a + b) & 1023] = w[8*b +: 8];
      end
   endtask

   task automatic model_seg(input int src, input int dst, input logic [31:0] ctl);
      int sz;
      sz = nbytes(ctl[13:12] == 2'd3 ? 2'd2 : ctl[13:12]);
      for (int k = 0; k < int'(ctl[11:0]); k++) begin
         int s, d;
         s = src + (ctl[14] ? k * sz : 0);
         d = dst + (ctl[15] ? k * sz : 0);
         for (int b = 0; b < sz; b++) ref_b[(d + b) & 1023] = ref_b[(s + b) & 1023];
      end
   endtask

   function automatic int mism();
      int m = 0;
      for (int i = 0; i < 1024; i++) if (mem_b[i] !== ref_b[i]) m++;
      return m;
   endfunction

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 3'd4; reg_wdata = '0;
   endtask

   task automatic load_regs(input int s, input int d, input int l, input logic [31:0] c);
      reg_write(3'd0, 32'(s));
      reg_write(3'd1, 32'(d));
      reg_write(3'd2, 32'(l));
      reg_write(3'd3, c);
   endtask

   task automatic run(input bit mask, input bit autoclr, output int nirq);
      nirq = 0;
      reg_write(3'd4, {30'b0, mask, 1'b1});
      for (int c = 0; c < 20000; c++) begin
         if (tc_irq && autoclr) begin
            nirq++;
            reg_write(3'd5, 32'd1);
         end else begin
            @(negedge clk);
         end
         reg_addr = 3'd4;
         #1;
         if (reg_rdata[0] == 1'b0) break;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      int nirq;
      fill(1);
      repeat (3) @(negedge clk);
      // R1: reset state
      check(tc_irq == 1'b0, "R1 irq", int'(tc_irq), 0);
      check(mem_req == 1'b0, "R1 req", int'(mem_req), 0);
      check(reg_rdata == 32'd0, "R1 cfg", int'(reg_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R5: single-segment vectors
      foreach (VEC[i]) begin
         logic [31:0] c;
         fill(i * 5 + 2);
         c = mk_ctrl(1'b0, VEC[i].dinc, VEC[i].sinc, VEC[i].wid, VEC[i].cnt);
         load_regs(int'(VEC[i].src), int'(VEC[i].dst), 0, c);
         model_seg(int'(VEC[i].src), int'(VEC[i].dst), c);
         run(1'b1, 1'b1, nirq);
         check(mism() == 0, "R2 R3 copy", mism(), 0);
         check(reg_rdata[0] == 1'b0, "R5 enable cleared", int'(reg_rdata[0]), 0);
         check(mem_req == 1'b0, "R10 idle after chain", int'(mem_req), 0);
      end

      // R4 R6 R7: chain, unaligned first link, zero-count middle item, irq on last only
      for (int mode = 0; mode < 3; mode++) begin
         bit ie_mid, mask;
         logic [31:0] c1, c2, c3;
         int exp_n;
         ie_mid = (mode == 1);
         mask   = (mode != 2);
         exp_n  = (mode == 0) ? 1 : (mode == 1) ? 3 : 0;
         fill(40 + mode);
         c1 = mk_ctrl(ie_mid || mode == 2, 1'b1, 1'b1, 2'd0, 12'd6);
         c2 = mk_ctrl(ie_mid || mode == 2, 1'b1, 1'b1, 2'd2, 12'd0);
         c3 = mk_ctrl(1'b1, 1'b1, 1'b1, 2'd2, 12'd3);
         put_word(32'h300, 32'h140);
         put_word(32'h304, 32'h240);
         put_word(32'h308, 32'h320);
         put_word(32'h30C, c2);
         put_word(32'h320, 32'h180);
         put_word(32'h324, 32'h280);
         put_word(32'h328, 32'h0);
         put_word(32'h32C, c3);
         load_regs(32'h100, 32'h200, 32'h301, c1);
         model_seg(32'h100, 32'h200, c1);
         model_seg(32'h180, 32'h280, c3);
         run(mask, 1'b1, nirq);
         check(mism() == 0, "R4 R6 chained copy", mism(), 0);
         check(nirq == exp_n, "R7 irq count", nirq, exp_n);
         check(tc_irq == 1'b0, "R8 cleared after W1C", int'(tc_irq), 0);
      end

      // R8: pending interrupt held, write 0 ignored, write 1 clears
      fill(77);
      load_regs(32'h100, 32'h200, 0, mk_ctrl(1'b1, 1'b1, 1'b1, 2'd1, 12'd2));
      model_seg(32'h100, 32'h200, mk_ctrl(1'b1, 1'b1, 1'b1, 2'd1, 12'd2));
      run(1'b1, 1'b0, nirq);
      repeat (5) @(negedge clk);
      check(tc_irq == 1'b1, "R8 irq held", int'(tc_irq), 1);
      reg_write(3'd5, 32'd0);
      @(negedge clk);
      check(tc_irq == 1'b1, "R8 write 0 ignored", int'(tc_irq), 1);
      reg_addr = 3'd5; #1;
      check(reg_rdata[0] == 1'b1, "R8 read pending", int'(reg_rdata[0]), 1);
      reg_write(3'd5, 32'd1);
      check(tc_irq == 1'b0, "R8 write 1 clears", int'(tc_irq), 0);
      check(mism() == 0, "R2 halfword copy", mism(), 0);

      // R6: lone zero-count segment with null link
      fill(90);
      load_regs(32'h100, 32'h200, 0, mk_ctrl(1'b1, 1'b1, 1'b1, 2'd0, 12'd0));
      run(1'b1, 1'b1, nirq);
      check(mism() == 0, "R6 nothing moved", mism(), 0);
      check(nirq == 1, "R6 R7 zero segment completes", nirq, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule